// File: doc/BRIEF.md
# Write Buffer with Read Bypass

This block sits between an upper and a lower level of a memory hierarchy and absorbs stores so that the requester never waits on the slower level. A write is taken into a small circular queue in the cycle it is offered, as long as a slot is free, and the queued writes are sent down to the lower level one at a time, oldest first, over a single valid/ready request channel.

Reads are given priority over the queued writes. Each read address is compared against every occupied slot. With no match, the read is sent to the lower level ahead of the waiting writes. With a match, the lower level is not touched and the data of the youngest matching slot is returned from the buffer. A configuration input switches to a conservative mode in which a read is only accepted once the queue is empty. Only one read is in flight at a time; responses come back on a registered response port.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset, wr_ready and rd_ready are 1, and mem_valid and rsp_valid are 0.
- R2: A write is accepted (wr_ready=1) whenever fewer than DEPTH writes are held, whatever the state of mem_ready; with DEPTH writes held, wr_ready is 0.
- R3: Held writes leave on the downstream channel with mem_we=1, in the order they were accepted, one per cycle in which mem_valid and mem_ready are both 1, carrying the accepted address and data unchanged.
- R4: A read whose address matches no held write is sent downstream as a request with mem_we=0, ahead of every held write not already being presented; its response data equals mem_rdata and rsp_valid rises in the cycle after mem_rvalid.
- R5: A read whose address matches a held write produces no downstream read, and rsp_valid is 1 in the cycle right after the read is accepted, with the held data.
- R6: When several held writes match a read address, the data of the most recently accepted one is returned.
- R7: While cfg_drain_first is 1 and any write is held, rd_ready is 0; the read then goes downstream after all held writes.
- R8: Once mem_valid is 1 with mem_ready 0, the request (mem_we, mem_addr, mem_wdata) stays presented and unchanged until accepted; a read arriving meanwhile waits behind it.
- R9: A write accepted in the same cycle as a read is treated as younger than that read: the read does not see its data.
- R10: At most one read is outstanding: after a read that goes downstream is accepted, rd_ready stays 0 until its response has been delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_drain_first | input | 1 | 1: hold every read until the queue is empty |
| wr_valid | input | 1 | Upstream write offered |
| wr_ready | output | 1 | Upstream write can be taken |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_valid | input | 1 | Upstream read offered |
| rd_ready | output | 1 | Upstream read can be taken |
| rd_addr | input | ADDR_W | Read address |
| rsp_valid | output | 1 | Read response valid (one cycle) |
| rsp_data | output | DATA_W | Read response data |
| mem_valid | output | 1 | Downstream request valid |
| mem_ready | input | 1 | Downstream request taken |
| mem_we | output | 1 | 1: write request, 0: read request |
| mem_addr | output | ADDR_W | Downstream request address |
| mem_wdata | output | DATA_W | Downstream write data (0 on reads) |
| mem_rvalid | input | 1 | Downstream read data valid |
| mem_rdata | input | DATA_W | Downstream read data |

## Verification
The assertions watch, every cycle, occupancy derived purely from port handshakes: that write back-pressure appears exactly when the queue is full, that no write is presented with an empty queue, that a stalled downstream request is held stable, that the drain-first gate keeps reads out while writes remain, and that no second read is accepted while one is outstanding. What only the directed scenarios can show is data correctness: that forwarded data is the youngest match, that the drain order matches acceptance order, that a bypassing read reaches the lower level before the remaining writes, and that a same-cycle write stays invisible to its companion read.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
    typedef enum logic [1:0] {
        WB_IDLE   = 2'd0,
        WB_RDREQ  = 2'd1,
        WB_RDWAIT = 2'd2
    } wb_rd_state_e;
endpackage

// File: rtl/wbuf_fifo.sv
`timescale 1ns/1ps
// Circular storage for held writes; all slots visible for the address search.
module wbuf_fifo #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] addr_o [DEPTH],
    output logic [DATA_W-1:0] data_o [DEPTH],
    output logic [PTR_W-1:0]  head_o,
    output logic [CNT_W-1:0]  count_o
);
    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [ADDR_W-1:0] addr_d [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DATA_W-1:0] data_d [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        ptr_d  = ptr_q;
        addr_d = addr_q;
        data_d = data_q;
        if (push_i) begin
            addr_d[ptr_q.tail] = push_addr_i;
            data_d[ptr_q.tail] = push_data_i;
            ptr_d.tail         = wrap_inc(ptr_q.tail);
        end
        if (pop_i) begin
            ptr_d.head = wrap_inc(ptr_q.head);
        end
        if (push_i && !pop_i) begin
            ptr_d.count = ptr_q.count + CNT_W'(1);
        end else if (pop_i && !push_i) begin
            ptr_d.count = ptr_q.count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    always_ff @(posedge clk) begin
        addr_q <= addr_d;
        data_q <= data_d;
    end

    assign addr_o  = addr_q;
    assign data_o  = data_q;
    assign head_o  = ptr_q.head;
    assign count_o = ptr_q.count;
endmodule

// File: rtl/wbuf_match.sv
`timescale 1ns/1ps
// Associative compare of one address against all occupied slots.
// Slots are scanned oldest to youngest; the last hit wins, giving the youngest.
module wbuf_match #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [ADDR_W-1:0] query_i,
    input  logic [ADDR_W-1:0] addr_i [DEPTH],
    input  logic [PTR_W-1:0]  head_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              hit_o,
    output logic [PTR_W-1:0]  idx_o
);
    logic [PTR_W:0]   pos   [DEPTH];
    logic [DEPTH-1:0] match_age;

    // Per-age slot position and match flag.
    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        logic [PTR_W:0] sum;
        assign sum    = {1'b0, head_i} + (PTR_W+1)'(g);
        assign pos[g] = (sum >= (PTR_W+1)'(DEPTH)) ? sum - (PTR_W+1)'(DEPTH) : sum;
        assign match_age[g] = (CNT_W'(g) < count_i) &&
                              (addr_i[pos[g][PTR_W-1:0]] == query_i);
    end

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match_age[i]) begin
                hit_o = 1'b1;
                idx_o = pos[i][PTR_W-1:0];
            end
        end
    end
endmodule

// File: rtl/wbuf_bypass.sv
`timescale 1ns/1ps
module wbuf_bypass #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_drain_first,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    import wbuf_pkg::*;

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        wb_rd_state_e      st;
        logic [ADDR_W-1:0] raddr;
        logic              lock;   // a write is on the channel, not yet taken
        logic              rvld;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] ent_addr [DEPTH];
    logic [DATA_W-1:0] ent_data [DEPTH];
    logic [PTR_W-1:0]  head;
    logic [CNT_W-1:0]  count;
    logic              hit;
    logic [PTR_W-1:0]  hit_idx;
    logic              empty, full;
    logic              wr_fire, rd_fire, pop;

    wbuf_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) fifo_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (wr_fire),
        .push_addr_i (wr_addr),
        .push_data_i (wr_data),
        .pop_i       (pop),
        .addr_o      (ent_addr),
        .data_o      (ent_data),
        .head_o      (head),
        .count_o     (count)
    );

    wbuf_match #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) match_i (
        .query_i (rd_addr),
        .addr_i  (ent_addr),
        .head_i  (head),
        .count_i (count),
        .hit_o   (hit),
        .idx_o   (hit_idx)
    );

    always_comb begin
        ctl_d = ctl_q;
        ctl_d.rvld = 1'b0;

        empty    = (count == '0);
        full     = (count == CNT_W'(DEPTH));
        wr_ready = !full;
        wr_fire  = wr_valid && wr_ready;
        rd_ready = (ctl_q.st == WB_IDLE) && !(cfg_drain_first && !empty);
        rd_fire  = rd_valid && rd_ready;

        // Downstream channel: a pending read goes first unless a write is stuck on it.
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        if (ctl_q.st == WB_RDREQ && !ctl_q.lock) begin
            mem_valid = 1'b1;
            mem_addr  = ctl_q.raddr;
        end else if (!empty) begin
            mem_valid = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = ent_addr[head];
            mem_wdata = ent_data[head];
        end
        pop        = mem_valid && mem_we && mem_ready;
        ctl_d.lock = mem_valid && mem_we && !mem_ready;

        unique case (ctl_q.st)
            WB_IDLE: begin
                if (rd_fire) begin
                    if (hit) begin
                        ctl_d.rvld  = 1'b1;
                        ctl_d.rdata = ent_data[hit_idx];
                    end else begin
                        ctl_d.st    = WB_RDREQ;
                        ctl_d.raddr = rd_addr;
                    end
                end
            end
            WB_RDREQ: begin
                if (!ctl_q.lock && mem_ready) begin
                    ctl_d.st = WB_RDWAIT;
                end
            end
            WB_RDWAIT: begin
                if (mem_rvalid) begin
                    ctl_d.rvld  = 1'b1;
                    ctl_d.rdata = mem_rdata;
                    ctl_d.st    = WB_IDLE;
                end
            end
            default: ctl_d.st = WB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: WB_IDLE, raddr: '0, lock: 1'b0, rvld: 1'b0, rdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid = ctl_q.rvld;
    assign rsp_data  = ctl_q.rdata;
endmodule

// File: rtl/wbuf_bypass_chk.sv
`timescale 1ns/1ps
module wbuf_bypass_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_drain_first,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic              rsp_valid,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_rvalid
);
    localparam int OCC_W = $clog2(DEPTH + 1) + 1;

    logic [OCC_W-1:0] occ;
    logic [1:0]       outst;
    logic             w_in, w_out, r_in;

    assign w_in  = wr_valid && wr_ready;
    assign w_out = mem_valid && mem_ready && mem_we;
    assign r_in  = rd_valid && rd_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ   <= '0;
            outst <= '0;
        end else begin
            occ   <= occ + OCC_W'(w_in) - OCC_W'(w_out);
            outst <= outst + 2'(r_in) - 2'(rsp_valid);
        end
    end

    // R2: back-pressure exactly when full, never past DEPTH
    p_full_backpressure_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready == (occ != OCC_W'(DEPTH))) && (occ <= OCC_W'(DEPTH)));

    // R3: a write only leaves when one is held
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> (occ != '0));

    // R4: downstream read data is turned into a response the next cycle
    p_rsp_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |=> rsp_valid);

    // R7: drain-first mode keeps reads out while writes are held
    p_drain_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_drain_first && occ != '0) |-> !rd_ready);

    // R8: a stalled downstream request is held unchanged
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R10: never more than one read in flight
    p_single_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        outst <= 2'd1);
endmodule

bind wbuf_bypass wbuf_bypass_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_drain_first (cfg_drain_first),
    .wr_valid        (wr_valid),
    .wr_ready        (wr_ready),
    .rd_valid        (rd_valid),
    .rd_ready        (rd_ready),
    .rsp_valid       (rsp_valid),
    .mem_valid       (mem_valid),
    .mem_ready       (mem_ready),
    .mem_we          (mem_we),
    .mem_addr        (mem_addr),
    .mem_wdata       (mem_wdata),
    .mem_rvalid      (mem_rvalid)
);

// File: tb/wbuf_bypass_tb_top.sv
`timescale 1ns/1ps
module wbuf_bypass_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int DEP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_drain_first = 1'b0;
    logic          wr_valid = 1'b0;
    logic          wr_ready;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_valid = 1'b0;
    logic          rd_ready;
    logic [AW-1:0] rd_addr = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_rvalid = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbuf_bypass #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_drain_first(cfg_drain_first),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Lower-level memory model and traffic log
    logic [DW-1:0] mem_arr [256];
    logic [DW-1:0] shadow  [256];
    logic [AW-1:0] wlog_a  [64];
    logic [DW-1:0] wlog_d  [64];
    int wcnt = 0, rcnt = 0, rd_at_w = 0, lat = 0;
    logic [DW-1:0] rd_hold = '0;
    int total = 0, bad = 0;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_arr[i] = 16'hA000 | 16'(i);
            shadow[i]  = 16'hA000 | 16'(i);
        end
    end

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (lat > 0) begin
            lat <= lat - 1;
            if (lat == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= rd_hold;
            end
        end
        if (mem_valid && mem_ready) begin
            if (mem_we) begin
                mem_arr[mem_addr] <= mem_wdata;
                wlog_a[wcnt % 64] <= mem_addr;
                wlog_d[wcnt % 64] <= mem_wdata;
                wcnt <= wcnt + 1;
            end else begin
                rd_hold <= mem_arr[mem_addr];
                rd_at_w <= wcnt;
                rcnt    <= rcnt + 1;
                lat     <= 2;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        while (!wr_ready) @(negedge clk);
        @(posedge clk);
        shadow[a] = d;
        #1 wr_valid = 1'b0;
    endtask

    task automatic wait_rsp(output logic [DW-1:0] got, output int cyc);
        got = 'x;
        cyc = 0;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            cyc++;
            if (rsp_valid) begin
                got = rsp_data;
                break;
            end
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] got,
                           output logic [DW-1:0] exp, output int cyc);
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = a;
        while (!rd_ready) @(negedge clk);
        exp = shadow[a];
        @(posedge clk);
        #1 rd_valid = 1'b0;
        wait_rsp(got, cyc);
    endtask

    task automatic wait_drain();
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            if (!mem_valid) break;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 wr_ready", 32'(wr_ready), 1);
        check("R1 rd_ready", 32'(rd_ready), 1);
        check("R1 mem_valid", 32'(mem_valid), 0);
        check("R1 rsp_valid", 32'(rsp_valid), 0);
    endtask

    task automatic t_fill_and_drain();
        int base;
        mem_ready = 1'b0;
        base = wcnt;
        for (int i = 0; i < DEP; i++) begin
            @(negedge clk);
            check("R2 ready while not full", 32'(wr_ready), 1);
            do_write(AW'(i + 1), DW'(16'h0100 + i));
        end
        @(negedge clk);
        check("R2 full back-pressure", 32'(wr_ready), 0);
        check("R3 head presented", 32'({mem_valid, mem_we}), 32'b11);
        check("R8 head address", 32'(mem_addr), 1);
        mem_ready = 1'b1;
        wait_drain();
        check("R3 drain count", 32'(wcnt - base), DEP);
        for (int i = 0; i < DEP; i++) begin
            check("R3 drain addr order", 32'(wlog_a[(base + i) % 64]), 32'(i + 1));
            check("R3 drain data order", 32'(wlog_d[(base + i) % 64]), 32'(16'h0100 + i));
        end
    endtask

    task automatic t_bypass();
        int base, rb;
        logic [DW-1:0] got, exp;
        int cyc;
        mem_ready = 1'b0;
        base = wcnt;
        rb = rcnt;
        do_write(8'h10, 16'h1010);
        do_write(8'h11, 16'h1111);
        do_write(8'h12, 16'h1212);
        fork
            do_read(8'h40, got, exp, cyc);
            begin
                repeat (3) @(negedge clk);
                mem_ready = 1'b1;
            end
        join
        check("R4 bypass data", 32'(got), 32'(exp));
        check("R4 one downstream read", 32'(rcnt - rb), 1);
        check("R8 read waited behind stalled head only", 32'(rd_at_w - base), 1);
        wait_drain();
        check("R3 remaining writes drained", 32'(wcnt - base), 3);
    endtask

    task automatic t_forward();
        int rb;
        logic [DW-1:0] got, exp;
        int cyc;
        mem_ready = 1'b0;
        rb = rcnt;
        do_write(8'h20, 16'h2001);
        do_read(8'h20, got, exp, cyc);
        check("R5 forward data", 32'(got), 32'h2001);
        check("R5 forward latency", 32'(cyc), 1);
        do_write(8'h30, 16'h3003);
        do_write(8'h20, 16'h2002);
        do_write(8'h31, 16'h3113);
        do_read(8'h20, got, exp, cyc);
        check("R6 youngest match", 32'(got), 32'h2002);
        check("R6 expected from model", 32'(got), 32'(exp));
        check("R5 no downstream read", 32'(rcnt - rb), 0);
        mem_ready = 1'b1;
        wait_drain();
    endtask

    task automatic t_drain_mode();
        int base, rb;
        logic [DW-1:0] got;
        int cyc;
        mem_ready = 1'b0;
        cfg_drain_first = 1'b1;
        do_write(8'h60, 16'h6006);
        do_write(8'h61, 16'h6116);
        base = wcnt;
        rb = rcnt;
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = 8'h60;
        @(negedge clk);
        check("R7 read held while writes remain", 32'(rd_ready), 0);
        mem_ready = 1'b1;
        while (!rd_ready) @(negedge clk);
        @(posedge clk);
        #1 rd_valid = 1'b0;
        wait_rsp(got, cyc);
        check("R7 data after drain", 32'(got), 32'h6006);
        check("R7 read issued after all writes", 32'(rd_at_w - base), 2);
        check("R7 read went downstream", 32'(rcnt - rb), 1);
        cfg_drain_first = 1'b0;
    endtask

    task automatic t_same_cycle();
        logic [DW-1:0] got, exp;
        int cyc;
        mem_ready = 1'b1;
        wait_drain();
        @(negedge clk);
        check("R9 both ports ready", 32'({wr_ready, rd_ready}), 32'b11);
        wr_valid = 1'b1; wr_addr = 8'h70; wr_data = 16'h7777;
        rd_valid = 1'b1; rd_addr = 8'h70;
        @(posedge clk);
        exp = shadow[8'h70];
        shadow[8'h70] = 16'h7777;
        #1 begin wr_valid = 1'b0; rd_valid = 1'b0; end
        wait_rsp(got, cyc);
        check("R9 same-cycle write not seen", 32'(got), 32'(exp));
        do_read(8'h70, got, exp, cyc);
        check("R9 later read sees write", 32'(got), 32'h7777);
    endtask

    task automatic t_single_read();
        logic [DW-1:0] got;
        int cyc;
        mem_ready = 1'b0;
        wait_drain();
        @(negedge clk);
        rd_valid = 1'b1; rd_addr = 8'h90;
        @(posedge clk);
        #1 rd_valid = 1'b0;
        @(negedge clk);
        check("R10 rd_ready low while read outstanding", 32'(rd_ready), 0);
        check("R4 read request presented", 32'({mem_valid, mem_we}), 32'b10);
        mem_ready = 1'b1;
        wait_rsp(got, cyc);
        check("R4 read data from memory", 32'(got), 32'hA090);
        check("R10 rd_ready back with response", 32'(rd_ready), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fill_and_drain();
        t_bypass();
        t_forward();
        t_drain_mode();
        t_same_cycle();
        t_single_read();
        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog (all requirements): actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule